// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block is the descriptor engine of a multi-channel display controller. On every frame-start strobe it walks its channels in ascending order and, for each enabled channel, reads a four-word descriptor from memory: the pointer to the next descriptor, the frame source address, a frame identifier and a command word. Each field is latched into that channel's registers, so the next frame follows the linked chain without software action.

Software can write each channel's descriptor-address register directly. It can also arm a one-shot branch, which redirects the next fetch to a new target. When that branch is taken it can raise an event. A descriptor pointer that falls outside the permitted memory windows is not fetched. A fetched source address that is zero or outside the windows is also treated as bad. In both cases a per-channel bus-error event fires, and the failing channel number is recorded in a status word whose layout a neighbouring block decodes.

Memory is reached through a simple read port with one request in flight at a time. The caller learns that a load cycle is complete from a one-cycle done pulse.

Top module: `frame_desc_fetch`

## Requirements
- R1: After reset every per-channel register (descriptor address, branch, source, ID, command) is zero, no event or done pulse is raised, `mem_req_valid` is low and `err_word` is zero.
- R2: A write with `wr_sel`=0 stores `wr_data & 0xFFFFFFF0` in the addressed channel's descriptor-address register. A write with `wr_sel`=1 stores `wr_data & 0xFFFFFFF3` in its branch register, where bit 0 is the branch request, bit 1 the branch-event enable and bits 31:4 the target.
- R3: A frame-start strobe seen while idle begins a load cycle. The cycle first clears every channel's source register, then services the enabled channels in ascending order. A disabled channel issues no read, keeps a zero source and leaves its branch register untouched.
- R4: A fetch from a valid address A issues exactly four reads, at A, A+4, A+8 and A+12. They return the next pointer (stored with bits 3:0 cleared into the descriptor-address register), the source, the ID and the command. Only one read is outstanding, and a request holds its address until accepted.
- R5: If branch bit 0 is set when a channel is serviced, the fetch address is the branch register with bits 3:0 cleared and bit 0 is then cleared. A one-cycle `branch_evt` pulse for that channel fires only if bit 1 is also set.
- R6: Without a pending branch request, the fetch address is the current descriptor-address register, which is normally the next pointer linked in by the previous fetch.
- R7: A descriptor address A is valid only if, for one window, base ≤ A and A+16 ≤ base+size. The windows are 0x0000_4000 with size 0x4000, and 0xA000_0000 with size 0x10_0000. An invalid address issues no read, pulses `bus_err_evt` for the channel and leaves its source at zero.
- R8: After a fetch, a source of zero, or one not satisfying base ≤ S < base+size for any window, pulses `bus_err_evt` for that channel. The fetched fields stay latched.
- R9: `err_word` bits 30:28 hold the number of the most recent channel to raise a bus error; all other bits are zero.
- R10: `done` is a one-cycle pulse after the last enabled channel is finished, including when no channel is enabled. A frame-start strobe during a load cycle is ignored.
- R11: Per channel, the block decodes the latched command word: the palette-load flag is bit 26, the start-of-frame interrupt enable is bit 22, the end-of-frame interrupt enable is bit 21, and the byte length is bits 20:2 with the two low bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Begins a load cycle when idle |
| chan_en | input | NCH | Per-channel enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: descriptor-address register, 1: branch register |
| wr_chan | input | clog2(NCH) | Channel addressed by the write |
| wr_data | input | 32 | Write data |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read word address (byte address) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | Load cycle finished |
| branch_evt | output | NCH | Branch taken with event enabled |
| bus_err_evt | output | NCH | Bus error on channel |
| err_word | output | 32 | Status word, failing channel at bits 30:28 |
| ch_desc | output | NCH*32 | Descriptor-address registers |
| ch_branch | output | NCH*32 | Branch registers |
| ch_src | output | NCH*32 | Latched source addresses |
| ch_id | output | NCH*32 | Latched frame IDs |
| ch_cmd | output | NCH*32 | Latched command words |
| ch_len | output | NCH*21 | Decoded byte lengths |
| ch_pal | output | NCH | Decoded palette-load flags |
| ch_sof_ie | output | NCH | Decoded start-of-frame interrupt enables |
| ch_eof_ie | output | NCH | Decoded end-of-frame interrupt enables |

## Verification
The assertions assume that the memory returns exactly one response for each accepted request, and never one unasked. They also assume that register writes and channel enables stay quiet while a load cycle runs; the branch-clear check only exempts a write at that same edge. The bench memory model gives ready only when nothing is pending, and answers each accepted read once after a random delay of zero to two cycles. It performs all register writes and enable changes between load cycles, after `done`.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SCAN  = 3'd1,
        ST_REQ   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_CHECK = 3'd4
    } fstate_e;

    localparam logic [31:0] DESC_KEEP = 32'hFFFF_FFF0;
    localparam logic [31:0] BR_KEEP   = 32'hFFFF_FFF3;
    localparam int BR_GO   = 0;
    localparam int BR_IRQ  = 1;
    localparam int CMD_EOF = 21;
    localparam int CMD_SOF = 22;
    localparam int CMD_PAL = 26;
    localparam int LEN_W   = 21;
endpackage

// File: rtl/fdf_win_chk.sv
module fdf_win_chk #(
    parameter logic [31:0] B0 = 32'h0000_4000,
    parameter logic [31:0] S0 = 32'h0000_4000,
    parameter logic [31:0] B1 = 32'hA000_0000,
    parameter logic [31:0] S1 = 32'h0010_0000,
    parameter int          SPAN = 16
) (
    input  logic [31:0] addr,
    output logic        ok
);
    localparam logic [32:0] LO0 = {1'b0, B0};
    localparam logic [32:0] HI0 = {1'b0, B0} + {1'b0, S0};
    localparam logic [32:0] LO1 = {1'b0, B1};
    localparam logic [32:0] HI1 = {1'b0, B1} + {1'b0, S1};

    logic [32:0] lo_a, hi_a;
    assign lo_a = {1'b0, addr};
    assign hi_a = lo_a + 33'(SPAN);
    assign ok = (lo_a >= LO0 && hi_a <= HI0) || (lo_a >= LO1 && hi_a <= HI1);
endmodule

// File: rtl/fdf_pick.sv
module fdf_pick #(
    parameter int NCH = 7,
    parameter int CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CW:0]    from,
    output logic           found,
    output logic [CW-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end
endmodule

// File: rtl/frame_desc_fetch.sv
module frame_desc_fetch
    import fdf_pkg::*;
#(
    parameter int          NCH     = 7,
    parameter logic [31:0] W0_BASE = 32'h0000_4000,
    parameter logic [31:0] W0_SIZE = 32'h0000_4000,
    parameter logic [31:0] W1_BASE = 32'hA000_0000,
    parameter logic [31:0] W1_SIZE = 32'h0010_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic [NCH-1:0]          chan_en,
    input  logic                    wr_en,
    input  logic                    wr_sel,
    input  logic [$clog2(NCH)-1:0]  wr_chan,
    input  logic [31:0]             wr_data,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [31:0]             mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [31:0]             mem_rsp_data,
    output logic                    done,
    output logic [NCH-1:0]          branch_evt,
    output logic [NCH-1:0]          bus_err_evt,
    output logic [31:0]             err_word,
    output logic [NCH*32-1:0]       ch_desc,
    output logic [NCH*32-1:0]       ch_branch,
    output logic [NCH*32-1:0]       ch_src,
    output logic [NCH*32-1:0]       ch_id,
    output logic [NCH*32-1:0]       ch_cmd,
    output logic [NCH*LEN_W-1:0]    ch_len,
    output logic [NCH-1:0]          ch_pal,
    output logic [NCH-1:0]          ch_sof_ie,
    output logic [NCH-1:0]          ch_eof_ie
);
    localparam int CW = $clog2(NCH);

    typedef struct packed {
        fstate_e                st;
        logic [CW-1:0]          cur;
        logic [CW:0]            from;
        logic [1:0]             word;
        logic [31:0]            base;
        logic [NCH-1:0][31:0]   desc;
        logic [NCH-1:0][31:0]   br;
        logic [NCH-1:0][31:0]   src;
        logic [NCH-1:0][31:0]   id;
        logic [NCH-1:0][31:0]   cmd;
        logic [NCH-1:0]         brev;
        logic [NCH-1:0]         berr;
        logic [2:0]             errch;
        logic                   done;
    } regs_t;

    regs_t d, q;

    logic          pick_found;
    logic [CW-1:0] pick_idx;
    logic [31:0]   pick_addr;
    logic          desc_ok, src_ok;
    logic          wr_hit;

    fdf_pick #(.NCH(NCH), .CW(CW)) u_pick (
        .mask (chan_en),
        .from (q.from),
        .found(pick_found),
        .idx  (pick_idx)
    );

    assign pick_addr = q.br[pick_idx][BR_GO] ? (q.br[pick_idx] & DESC_KEEP)
                                             : q.desc[pick_idx];

    fdf_win_chk #(.B0(W0_BASE), .S0(W0_SIZE), .B1(W1_BASE), .S1(W1_SIZE),
                  .SPAN(16)) u_desc_win (
        .addr(pick_addr),
        .ok  (desc_ok)
    );

    fdf_win_chk #(.B0(W0_BASE), .S0(W0_SIZE), .B1(W1_BASE), .S1(W1_SIZE),
                  .SPAN(1)) u_src_win (
        .addr(q.src[q.cur]),
        .ok  (src_ok)
    );

    assign wr_hit = wr_en && (int'(wr_chan) < NCH);

    always_comb begin
        d      = q;
        d.brev = '0;
        d.berr = '0;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (frame_start) begin
                    d.src  = '0;
                    d.from = '0;
                    d.st   = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (!pick_found) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.cur  = pick_idx;
                    d.from = {1'b0, pick_idx} + 1'b1;
                    if (q.br[pick_idx][BR_GO]) begin
                        d.br[pick_idx][BR_GO] = 1'b0;
                        d.brev[pick_idx]      = q.br[pick_idx][BR_IRQ];
                    end
                    if (!desc_ok) begin
                        d.berr[pick_idx] = 1'b1;
                        d.errch          = 3'(pick_idx);
                    end else begin
                        d.base = pick_addr;
                        d.word = 2'd0;
                        d.st   = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (q.word)
                        2'd0: d.desc[q.cur] = mem_rsp_data & DESC_KEEP;
                        2'd1: d.src[q.cur]  = mem_rsp_data;
                        2'd2: d.id[q.cur]   = mem_rsp_data;
                        default: d.cmd[q.cur] = mem_rsp_data;
                    endcase
                    if (q.word == 2'd3) begin
                        d.st = ST_CHECK;
                    end else begin
                        d.word = q.word + 2'd1;
                        d.st   = ST_REQ;
                    end
                end
            end
            ST_CHECK: begin
                if ((q.src[q.cur] == 32'd0) || !src_ok) begin
                    d.berr[q.cur] = 1'b1;
                    d.errch       = 3'(q.cur);
                end
                d.st = ST_SCAN;
            end
            default: d.st = ST_IDLE;
        endcase
        // software writes win over the engine's update of the same register
        if (wr_hit) begin
            if (wr_sel) d.br[wr_chan]   = wr_data & BR_KEEP;
            else        d.desc[wr_chan] = wr_data & DESC_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req_valid = (q.st == ST_REQ);
    assign mem_req_addr  = q.base + {28'd0, q.word, 2'b00};
    assign done          = q.done;
    assign branch_evt    = q.brev;
    assign bus_err_evt   = q.berr;
    assign err_word      = {1'b0, q.errch, 28'd0};
    assign ch_desc       = q.desc;
    assign ch_branch     = q.br;
    assign ch_src        = q.src;
    assign ch_id         = q.id;
    assign ch_cmd        = q.cmd;

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign ch_pal[g]    = q.cmd[g][CMD_PAL];
        assign ch_sof_ie[g] = q.cmd[g][CMD_SOF];
        assign ch_eof_ie[g] = q.cmd[g][CMD_EOF];
        assign ch_len[g*LEN_W +: LEN_W] = {q.cmd[g][20:2], 2'b00};

        // R5
        br_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (branch_evt[g] && !$past(wr_en && wr_sel && (int'(wr_chan) == g)))
            |-> !ch_branch[g*32 + BR_GO]);
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    bus_err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_err_evt));

    // R5
    branch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(branch_evt));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    no_req_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req_valid);
endmodule

// File: tb/sim_frame_desc_fetch.sv
`timescale 1ns/1ps
module sim_frame_desc_fetch;
    localparam int NCH = 7;
    localparam logic [31:0] W0B = 32'h0000_4000, W0S = 32'h0000_4000;
    localparam logic [31:0] W1B = 32'hA000_0000, W1S = 32'h0010_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic [NCH-1:0] chan_en = '0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [2:0] wr_chan = '0;
    logic [31:0] wr_data = '0;
    logic mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_rsp_data;
    logic done;
    logic [NCH-1:0] branch_evt, bus_err_evt, ch_pal, ch_sof_ie, ch_eof_ie;
    logic [31:0] err_word;
    logic [NCH*32-1:0] ch_desc, ch_branch, ch_src, ch_id, ch_cmd;
    logic [NCH*21-1:0] ch_len;

    always #2.5 clk = ~clk;

    frame_desc_fetch u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .chan_en(chan_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_chan(wr_chan), .wr_data(wr_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .branch_evt(branch_evt),
        .bus_err_evt(bus_err_evt), .err_word(err_word), .ch_desc(ch_desc),
        .ch_branch(ch_branch), .ch_src(ch_src), .ch_id(ch_id), .ch_cmd(ch_cmd),
        .ch_len(ch_len), .ch_pal(ch_pal), .ch_sof_ie(ch_sof_ie), .ch_eof_ie(ch_eof_ie)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model
    logic [31:0] mem [logic [31:0]];
    logic [31:0] acc_q[$];
    logic [31:0] exp_q[$];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : (a ^ 32'h5A5A_0000);
    endfunction

    initial begin
        bit pend = 0;
        int dly = 0;
        logic [31:0] pa = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_req_ready = 1'b0;
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(pa);
                    pend = 0;
                end else dly--;
            end else begin
                mem_req_ready = ($urandom % 4) != 0;
                if (mem_req_ready && mem_req_valid && rst_n) begin
                    pend = 1; pa = mem_req_addr; dly = $urandom % 3;
                    acc_q.push_back(mem_req_addr);
                end
            end
        end
    end

    // event observers
    int obs_brev[NCH], obs_berr[NCH], obs_done;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int c = 0; c < NCH; c++) begin
                    if (branch_evt[c]) obs_brev[c]++;
                    if (bus_err_evt[c]) obs_berr[c]++;
                end
                if (done) obs_done++;
            end
        end
    end

    // reference model
    logic [31:0] m_desc[NCH], m_br[NCH], m_src[NCH], m_id[NCH], m_cmd[NCH];
    int e_brev[NCH], e_berr[NCH];
    int last_err = 0;

    function automatic bit dok(input logic [31:0] a);
        longint unsigned x = longint'(a);
        return (x >= longint'(W0B) && x + 16 <= longint'(W0B) + longint'(W0S)) ||
               (x >= longint'(W1B) && x + 16 <= longint'(W1B) + longint'(W1S));
    endfunction

    function automatic bit sok(input logic [31:0] a);
        longint unsigned x = longint'(a);
        return (x >= longint'(W0B) && x < longint'(W0B) + longint'(W0S)) ||
               (x >= longint'(W1B) && x < longint'(W1B) + longint'(W1S));
    endfunction

    function automatic logic [31:0] rand_ok();
        if ($urandom % 2) return W0B + (($urandom % (W0S / 16)) * 16);
        return W1B + (($urandom % (W1S / 16)) * 16);
    endfunction

    function automatic logic [31:0] rand_src();
        int r = $urandom % 8;
        if (r == 0) return 32'd0;
        if (r == 1) return W0B - 4;
        if (r == 2) return W1B + W1S;
        return rand_ok() + (($urandom % 4) * 4);
    endfunction

    task automatic fill(input logic [31:0] a, input logic [31:0] s);
        mem[a]      = rand_ok() | ($urandom % 16);
        mem[a + 4]  = s;
        mem[a + 8]  = $urandom;
        mem[a + 12] = $urandom;
    endtask

    task automatic wr(input bit sel, input int ch, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_chan = 3'(ch); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_br[ch] = v & 32'hFFFF_FFF3;
        else     m_desc[ch] = v & 32'hFFFF_FFF0;
    endtask

    task automatic predict(input logic [NCH-1:0] en);
        logic [31:0] a;
        exp_q.delete();
        for (int c = 0; c < NCH; c++) begin
            m_src[c] = '0; e_brev[c] = 0; e_berr[c] = 0;
        end
        for (int c = 0; c < NCH; c++) begin
            if (!en[c]) continue;
            if (m_br[c][0]) begin
                a = m_br[c] & 32'hFFFF_FFF0;
                if (m_br[c][1]) e_brev[c] = 1;
                m_br[c][0] = 1'b0;
            end else a = m_desc[c];
            if (!dok(a)) begin
                e_berr[c] = 1; last_err = c;
                continue;
            end
            for (int k = 0; k < 4; k++) exp_q.push_back(a + 32'(4 * k));
            m_desc[c] = rd(a) & 32'hFFFF_FFF0;
            m_src[c]  = rd(a + 4);
            m_id[c]   = rd(a + 8);
            m_cmd[c]  = rd(a + 12);
            if (m_src[c] == 0 || !sok(m_src[c])) begin
                e_berr[c] = 1; last_err = c;
            end
        end
    endtask

    task automatic run_frame(input logic [NCH-1:0] en, input bit poke, input string tag);
        int t = 0;
        predict(en);
        acc_q.delete();
        obs_done = 0;
        for (int c = 0; c < NCH; c++) begin obs_brev[c] = 0; obs_berr[c] = 0; end
        @(negedge clk);
        chan_en = en; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            frame_start = 1'b1;              // R10: must be ignored while busy
            @(negedge clk);
            frame_start = 1'b0;
        end
        while (obs_done == 0 && t < 20000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        chk({tag, " R10 done pulses"}, 32'(obs_done), 32'd1);
        chk({tag, " R3 read count"}, 32'(acc_q.size()), 32'(exp_q.size()));
        if (acc_q.size() == exp_q.size())
            for (int i = 0; i < exp_q.size(); i++)
                chk({tag, " R4 read address order"}, acc_q[i], exp_q[i]);
        for (int c = 0; c < NCH; c++) begin
            chk({tag, " R4 next pointer"}, ch_desc[c*32 +: 32], m_desc[c]);
            chk({tag, " R5 branch reg"}, ch_branch[c*32 +: 32], m_br[c]);
            chk({tag, " R3 source"}, ch_src[c*32 +: 32], m_src[c]);
            chk({tag, " R4 id"}, ch_id[c*32 +: 32], m_id[c]);
            chk({tag, " R4 cmd"}, ch_cmd[c*32 +: 32], m_cmd[c]);
            chk({tag, " R5 branch events"}, 32'(obs_brev[c]), 32'(e_brev[c]));
            chk({tag, " R7 R8 bus errors"}, 32'(obs_berr[c]), 32'(e_berr[c]));
            chk({tag, " R11 decode"},
                {8'd0, ch_pal[c], ch_sof_ie[c], ch_eof_ie[c], ch_len[c*21 +: 21]},
                {8'd0, m_cmd[c][26], m_cmd[c][22], m_cmd[c][21], m_cmd[c][20:2], 2'b00});
        end
        chk({tag, " R9 error word"}, err_word, {1'b0, 3'(last_err), 28'd0});
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < NCH; c++) begin
            m_desc[c] = '0; m_br[c] = '0; m_src[c] = '0; m_id[c] = '0; m_cmd[c] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 desc", ch_desc[31:0] | ch_desc[NCH*32-1 -: 32], 32'd0);
        chk("R1 branch/src", ch_branch[63:0] == '0 && ch_src == '0 ? 32'd0 : 32'd1, 32'd0);
        chk("R1 outputs", {27'd0, done, mem_req_valid, |branch_evt, |bus_err_evt, |ch_cmd}, 32'd0);
        chk("R1 err word", err_word, 32'd0);

        // R2 write masking
        wr(0, 0, 32'hFFFF_FFFF);
        chk("R2 desc mask", ch_desc[31:0], 32'hFFFF_FFF0);
        wr(1, 1, 32'hFFFF_FFFF);
        chk("R2 branch mask", ch_branch[63:32], 32'hFFFF_FFF3);
        wr(1, 1, 32'd0);
        wr(0, 0, 32'd0);

        // R10 no channel enabled
        run_frame('0, 0, "empty");

        // R7 R8 R5 boundary cases
        wr(0, 0, W0B + W0S - 16); fill(W0B + W0S - 16, W0B + W0S - 1);
        wr(0, 1, W0B + W0S);                         // R7 window end: invalid
        wr(0, 2, W1B); fill(W1B, W1B + W1S);         // R8 source just past window
        wr(0, 3, W1B + 32'h40); fill(W1B + 32'h40, W1B);
        wr(0, 4, W0B + 32'h100); fill(W0B + 32'h100, 32'd0);  // R8 zero source
        fill(W0B + 32'h200, W0B + 32'h20);
        wr(1, 5, W0B + 32'h200 + 32'h1);             // R5 branch, no event
        fill(W1B + 32'h800, W1B + 32'h24);
        wr(1, 6, W1B + 32'h800 + 32'h3);             // R5 branch with event
        run_frame(7'h7F, 0, "boundary");

        // R6 chained fetch from latched next pointers, plus ignored strobe
        run_frame(7'h7F, 1, "R6 chain");

        // random frames
        for (int f = 0; f < 40; f++) begin
            for (int c = 0; c < NCH; c++) begin
                int r = $urandom % 10;
                logic [31:0] a;
                if (r < 6) begin
                    a = rand_ok(); fill(a, rand_src()); wr(0, c, a);
                end else if (r < 8) begin
                    wr(0, c, (r == 6) ? 32'd0 : (W0B + W0S));
                end
                if ($urandom % 4 == 0) begin
                    a = rand_ok(); fill(a, rand_src());
                    wr(1, c, a | 32'h1 | (($urandom % 2) << 1));
                end
            end
            run_frame(NCH'($urandom), (f % 8) == 3 ? 1'b0 : 1'b0, "random");
        end
        run_frame(7'h7F, 1, "random busy");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule